// File: doc/BRIEF.md
# Fractional-N Feedback Divider Modulator

This block sets the feedback division of a fractional-N synthesiser. It runs on the oscillator clock and emits a single-clock pulse `fb_pulse` at the end of each division cycle. Each cycle lasts either the integer part of the ratio or one clock more. A first-order phase accumulator selects the longer cycle. Its increment is the fractional word with a half-LSB always appended, so the long-run ratio is `MINT + (MFRAC + 0.5) / 2^FRAC_W`. The quantisation error is pushed toward high frequencies. When modulation is off, every cycle lasts exactly `MINT` clocks.

A configuration bank presents a new integer part, fractional word and modulation mode together with a one-clock load strobe. The block keeps the values it is given and does not apply them at once. They take effect at the next cycle boundary, and the accumulator restarts from zero at that boundary, so no division cycle is ever cut short or stretched by a mid-cycle update. `fb_ratio` shows the length of the cycle in progress.

Top module: `fnd_modulator`

## Requirements
- R1: While `rst_n` is low, `fb_pulse` is 0 and `fb_ratio` equals `RST_MINT`. After reset, the block divides by `RST_MINT` in integer mode until the first load.
- R2: `fb_pulse` is high for exactly one clock per division cycle. The number of clocks from one pulse to the next equals the `fb_ratio` shown during that cycle.
- R3: In integer mode (`cfg_mod_en` = 0 at load), every cycle lasts exactly the loaded MINT clocks, whatever the fractional word holds.
- R4: In fractional mode (`cfg_mod_en` = 1 at load), every cycle lasts MINT or MINT+1 clocks.
- R5: In fractional mode, starting with the second cycle after the configuration is applied, any 2^(FRAC_W+1) consecutive cycles total exactly MINT·2^(FRAC_W+1) + 2·MFRAC + 1 clocks.
- R6: Inputs are captured only on a clock where `cfg_load` = 1. Changes to them at other times have no effect. Captured values take effect at the first cycle boundary after the strobe, and the cycle in progress finishes at its old length.
- R7: The accumulator is cleared at the boundary where new values are applied, so the first cycle under a new configuration lasts exactly MINT clocks.
- R8: If a second strobe arrives before the boundary, the later values replace the earlier ones, and only the later values are ever applied.
- R9: Every MINT from 1 to 2^MINT_W−1 is supported. With MINT = 1 the block can produce one-clock cycles, and with the largest MINT it can produce cycles of 2^MINT_W clocks.
- R10: `fb_ratio` changes only on the clock edge that directly follows an `fb_pulse` clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| vco_clk | input | 1 | Oscillator clock being divided |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_load | input | 1 | One-clock strobe that captures the three values below |
| cfg_mint | input | MINT_W | Integer part of the ratio; must be non-zero |
| cfg_frac | input | FRAC_W | Fractional word |
| cfg_mod_en | input | 1 | 1 = fractional dither, 0 = integer-only division |
| fb_pulse | output | 1 | One-clock pulse at the end of each division cycle |
| fb_ratio | output | MINT_W+1 | Length in clocks of the cycle in progress |

## Verification
The checks assume that a strobe never carries an integer part of zero. A zero ratio has no meaning for the counter, and that rule is checked on every load. The stimulus keeps to MINT values from 1 to 127 and issues each strobe right after a pulse in cycles of at least five clocks, so the boundary at which a load lands is always known. A behavioural reference in the bench follows each clock. It is combined with sums taken over full accumulator periods at the smallest, largest and middle fractional settings.

// File: rtl/fnd_pkg.sv
package fnd_pkg;

    typedef enum logic {
        MODE_INT  = 1'b0,
        MODE_FRAC = 1'b1
    } div_mode_e;

    function automatic int unsigned len_width(int unsigned mint_w);
        return mint_w + 1;
    endfunction

endpackage

// File: rtl/fnd_cfg_shadow.sv
module fnd_cfg_shadow
    import fnd_pkg::*;
#(
    parameter int unsigned MINT_W   = 7,
    parameter int unsigned FRAC_W   = 18,
    parameter int unsigned RST_MINT = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load_i,
    input  logic [MINT_W-1:0] mint_i,
    input  logic [FRAC_W-1:0] frac_i,
    input  div_mode_e         mode_i,
    input  logic              boundary_i,
    output logic              apply_o,
    output logic [MINT_W-1:0] nxt_mint_o,
    output logic [FRAC_W-1:0] nxt_frac_o,
    output div_mode_e         nxt_mode_o,
    output logic [MINT_W-1:0] act_mint_o,
    output div_mode_e         act_mode_o
);

    typedef struct packed {
        logic              pend;
        logic [MINT_W-1:0] p_mint;
        logic [FRAC_W-1:0] p_frac;
        div_mode_e         p_mode;
        logic [MINT_W-1:0] a_mint;
        logic [FRAC_W-1:0] a_frac;
        div_mode_e         a_mode;
    } shadow_t;

    localparam shadow_t SHADOW_RST = '{
        pend:   1'b0,
        p_mint: MINT_W'(RST_MINT),
        p_frac: '0,
        p_mode: MODE_INT,
        a_mint: MINT_W'(RST_MINT),
        a_frac: '0,
        a_mode: MODE_INT
    };

    shadow_t st_d, st_q;
    logic    apply;

    always_comb begin
        st_d  = st_q;
        apply = boundary_i && st_q.pend;
        if (apply) begin
            st_d.a_mint = st_q.p_mint;
            st_d.a_frac = st_q.p_frac;
            st_d.a_mode = st_q.p_mode;
            st_d.pend   = 1'b0;
        end
        if (load_i) begin
            st_d.p_mint = mint_i;
            st_d.p_frac = frac_i;
            st_d.p_mode = mode_i;
            st_d.pend   = 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= SHADOW_RST;
        end else begin
            st_q <= st_d;
        end
    end

    assign apply_o    = apply;
    assign nxt_mint_o = st_d.a_mint;
    assign nxt_frac_o = st_d.a_frac;
    assign nxt_mode_o = st_d.a_mode;
    assign act_mint_o = st_q.a_mint;
    assign act_mode_o = st_q.a_mode;

endmodule

// File: rtl/fnd_accum.sv
module fnd_accum
    import fnd_pkg::*;
#(
    parameter int unsigned FRAC_W = 18
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              step_i,
    input  logic              clear_i,
    input  div_mode_e         mode_i,
    input  logic [FRAC_W-1:0] frac_i,
    output logic              carry_o
);

    localparam int unsigned ACC_W = FRAC_W + 1;

    typedef struct packed {
        logic [ACC_W-1:0] acc;
    } accum_t;

    accum_t         st_d, st_q;
    logic [ACC_W:0] sum;
    logic           carry;

    always_comb begin
        st_d  = st_q;
        sum   = {1'b0, st_q.acc} + {1'b0, frac_i, 1'b1};
        carry = 1'b0;
        if (clear_i) begin
            st_d.acc = '0;
        end else if (step_i && (mode_i == MODE_FRAC)) begin
            st_d.acc = sum[ACC_W-1:0];
            carry    = sum[ACC_W];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign carry_o = carry;

endmodule

// File: rtl/fnd_cycle_cnt.sv
module fnd_cycle_cnt #(
    parameter int unsigned CNT_W   = 8,
    parameter int unsigned RST_LEN = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [CNT_W-1:0] len_i,
    output logic             boundary_o,
    output logic [CNT_W-1:0] cnt_o,
    output logic [CNT_W-1:0] len_o
);

    typedef struct packed {
        logic [CNT_W-1:0] cnt;
        logic [CNT_W-1:0] len;
    } cnt_t;

    localparam cnt_t CNT_RST = '{
        cnt: CNT_W'(RST_LEN - 1),
        len: CNT_W'(RST_LEN)
    };

    cnt_t st_d, st_q;
    logic boundary;

    always_comb begin
        st_d     = st_q;
        boundary = (st_q.cnt == '0);
        if (boundary) begin
            st_d.cnt = len_i - CNT_W'(1);
            st_d.len = len_i;
        end else begin
            st_d.cnt = st_q.cnt - CNT_W'(1);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= CNT_RST;
        end else begin
            st_q <= st_d;
        end
    end

    assign boundary_o = boundary;
    assign cnt_o      = st_q.cnt;
    assign len_o      = st_q.len;

endmodule

// File: rtl/fnd_modulator.sv
module fnd_modulator
    import fnd_pkg::*;
#(
    parameter int unsigned MINT_W   = 7,
    parameter int unsigned FRAC_W   = 18,
    parameter int unsigned RST_MINT = 8
) (
    input  logic                    vco_clk,
    input  logic                    rst_n,
    input  logic                    cfg_load,
    input  logic [MINT_W-1:0]       cfg_mint,
    input  logic [FRAC_W-1:0]       cfg_frac,
    input  logic                    cfg_mod_en,
    output logic                    fb_pulse,
    output logic [MINT_W:0]         fb_ratio
);

    localparam int unsigned CNT_W = len_width(MINT_W);

    div_mode_e         cfg_mode;
    logic              boundary;
    logic              apply;
    logic [MINT_W-1:0] nxt_mint;
    logic [FRAC_W-1:0] nxt_frac;
    div_mode_e         nxt_mode;
    logic [MINT_W-1:0] act_mint;
    div_mode_e         act_mode;
    logic              carry;
    logic [CNT_W-1:0]  nxt_len;
    logic [CNT_W-1:0]  cyc_cnt;
    logic [CNT_W-1:0]  cur_len;

    assign cfg_mode = cfg_mod_en ? MODE_FRAC : MODE_INT;

    fnd_cfg_shadow #(
        .MINT_W   (MINT_W),
        .FRAC_W   (FRAC_W),
        .RST_MINT (RST_MINT)
    ) u_shadow (
        .clk        (vco_clk),
        .rst_n      (rst_n),
        .load_i     (cfg_load),
        .mint_i     (cfg_mint),
        .frac_i     (cfg_frac),
        .mode_i     (cfg_mode),
        .boundary_i (boundary),
        .apply_o    (apply),
        .nxt_mint_o (nxt_mint),
        .nxt_frac_o (nxt_frac),
        .nxt_mode_o (nxt_mode),
        .act_mint_o (act_mint),
        .act_mode_o (act_mode)
    );

    fnd_accum #(
        .FRAC_W (FRAC_W)
    ) u_accum (
        .clk     (vco_clk),
        .rst_n   (rst_n),
        .step_i  (boundary),
        .clear_i (apply),
        .mode_i  (nxt_mode),
        .frac_i  (nxt_frac),
        .carry_o (carry)
    );

    // Length of the next cycle: integer part plus the accumulator overflow
    assign nxt_len = {1'b0, nxt_mint} + CNT_W'(carry);

    fnd_cycle_cnt #(
        .CNT_W   (CNT_W),
        .RST_LEN (RST_MINT)
    ) u_cnt (
        .clk        (vco_clk),
        .rst_n      (rst_n),
        .len_i      (nxt_len),
        .boundary_o (boundary),
        .cnt_o      (cyc_cnt),
        .len_o      (cur_len)
    );

    assign fb_pulse = boundary;
    assign fb_ratio = cur_len;

endmodule

// File: rtl/fnd_modulator_chk.sv
module fnd_modulator_chk #(
    parameter int unsigned MINT_W = 7
) (
    input logic              clk,
    input logic              rst_n,
    input logic              cfg_load,
    input logic [MINT_W-1:0] cfg_mint,
    input logic              fb_pulse,
    input logic [MINT_W:0]   fb_ratio,
    input logic [MINT_W-1:0] act_mint,
    input logic              act_frac,
    input logic              apply,
    input logic [MINT_W:0]   cyc_cnt
);

    // R9: a zero integer part is never loaded
    a_r9_mint_nonzero: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_load |-> (cfg_mint != '0));

    a_r10_ratio_held: assert property (@(posedge clk) disable iff (!rst_n)
        !fb_pulse |=> $stable(fb_ratio));

    a_r2_reload: assert property (@(posedge clk) disable iff (!rst_n)
        fb_pulse |=> (cyc_cnt == fb_ratio - 1'b1));

    a_r2_countdown: assert property (@(posedge clk) disable iff (!rst_n)
        !fb_pulse |=> (cyc_cnt == $past(cyc_cnt) - 1'b1));

    a_r4_ratio_band: assert property (@(posedge clk) disable iff (!rst_n)
        (fb_ratio == {1'b0, act_mint}) || (fb_ratio == {1'b0, act_mint} + 1'b1));

    a_r3_int_exact: assert property (@(posedge clk) disable iff (!rst_n)
        !act_frac |-> (fb_ratio == {1'b0, act_mint}));

    a_r7_clear_on_apply: assert property (@(posedge clk) disable iff (!rst_n)
        apply |=> (fb_ratio == {1'b0, act_mint}));

endmodule

bind fnd_modulator fnd_modulator_chk #(
    .MINT_W (MINT_W)
) u_chk (
    .clk      (vco_clk),
    .rst_n    (rst_n),
    .cfg_load (cfg_load),
    .cfg_mint (cfg_mint),
    .fb_pulse (fb_pulse),
    .fb_ratio (fb_ratio),
    .act_mint (act_mint),
    .act_frac (act_mode == fnd_pkg::MODE_FRAC),
    .apply    (apply),
    .cyc_cnt  (cyc_cnt)
);

// File: tb/tb_fnd_modulator.sv
module tb_fnd_modulator;
    timeunit 1ns;
    timeprecision 100ps;

    localparam int MINT_W   = 7;
    localparam int FRAC_W   = 6;
    localparam int RST_MINT = 5;
    localparam int PERIOD   = 1 << (FRAC_W + 1);

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              cfg_load = 1'b0;
    logic [MINT_W-1:0] cfg_mint = '0;
    logic [FRAC_W-1:0] cfg_frac = '0;
    logic              cfg_mod_en = 1'b0;
    logic              fb_pulse;
    logic [MINT_W:0]   fb_ratio;

    int n_checks = 0;
    int n_fail   = 0;
    bit finished = 0;

    always #2.5 clk = ~clk;

    fnd_modulator #(
        .MINT_W   (MINT_W),
        .FRAC_W   (FRAC_W),
        .RST_MINT (RST_MINT)
    ) dut (
        .vco_clk    (vco_clk_w),
        .rst_n      (rst_n),
        .cfg_load   (cfg_load),
        .cfg_mint   (cfg_mint),
        .cfg_frac   (cfg_frac),
        .cfg_mod_en (cfg_mod_en),
        .fb_pulse   (fb_pulse),
        .fb_ratio   (fb_ratio)
    );

    wire vco_clk_w;
    assign vco_clk_w = clk;

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
        end
    endtask

    // Behavioural reference: one division cycle at a time
    int m_cnt, m_len, m_acc, am, af, ae, pm, pf, pe;
    bit m_pend;

    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            m_cnt = RST_MINT - 1; m_len = RST_MINT; m_acc = 0;
            am = RST_MINT; af = 0; ae = 0; m_pend = 0; pm = 0; pf = 0; pe = 0;
        end else begin
            if (m_cnt == 0) begin
                if (m_pend) begin
                    am = pm; af = pf; ae = pe; m_pend = 0; m_acc = 0; m_len = am;
                end else if (ae != 0) begin
                    int s;
                    s = m_acc + 2 * af + 1;
                    m_len = am + ((s >= PERIOD) ? 1 : 0);
                    m_acc = s % PERIOD;
                end else begin
                    m_len = am;
                end
                m_cnt = m_len - 1;
            end else begin
                m_cnt--;
            end
            if (cfg_load) begin
                m_pend = 1; pm = int'(cfg_mint); pf = int'(cfg_frac); pe = int'(cfg_mod_en);
            end
        end
    end

    always @(negedge clk) begin
        if (rst_n && !finished) begin
            check(fb_pulse == (m_cnt == 0), "R2 pulse vs reference", int'(fb_pulse), int'(m_cnt == 0));
            check(int'(fb_ratio) == m_len, "R6 ratio vs reference", int'(fb_ratio), m_len);
        end
    end

    task automatic sync_pulse();
        do @(negedge clk); while (!fb_pulse);
    endtask

    task automatic next_cycle(output int len, output int rat);
        bit steady;
        steady = 1;
        @(negedge clk);
        len = 1;
        rat = int'(fb_ratio);
        while (!fb_pulse) begin
            @(negedge clk);
            len++;
            if (int'(fb_ratio) != rat) steady = 0;
        end
        check(steady, "R10 ratio steady in cycle", 0, 1);
        check(len == rat, "R2 cycle length equals ratio", len, rat);
    endtask

    task automatic do_load(input int m, input int f, input bit e);
        @(negedge clk);
        cfg_mint = MINT_W'(m); cfg_frac = FRAC_W'(f); cfg_mod_en = e; cfg_load = 1'b1;
        @(negedge clk);
        cfg_load = 1'b0;
    endtask

    task automatic run_period(output int sum, output int mn, output int mx, input int lo, input string tag);
        int l, r;
        sum = 0; mn = 1 << 30; mx = 0;
        for (int i = 0; i < PERIOD; i++) begin
            next_cycle(l, r);
            sum += l;
            if (l < mn) mn = l;
            if (l > mx) mx = l;
        end
        check(mn >= lo && mx <= lo + 1, tag, mx, lo + 1);
    endtask

    initial begin
        int l, r, sum, mn, mx;
        repeat (3) @(negedge clk);
        // R1: reset state
        check(fb_pulse == 1'b0, "R1 pulse low in reset", int'(fb_pulse), 0);
        check(int'(fb_ratio) == RST_MINT, "R1 ratio in reset", int'(fb_ratio), RST_MINT);
        rst_n = 1'b1;
        sync_pulse();
        for (int i = 0; i < 3; i++) begin
            next_cycle(l, r);
            check(l == RST_MINT, "R1 default division", l, RST_MINT);
        end

        // R3: integer mode, fractional word ignored
        sync_pulse();
        do_load(9, 37, 1'b0);
        sync_pulse();
        for (int i = 0; i < 20; i++) begin
            next_cycle(l, r);
            check(l == 9, "R3 integer cycle length", l, 9);
        end

        // R6: mid-cycle load does not disturb the running cycle
        sync_pulse();
        do_load(12, 0, 1'b0);
        check(int'(fb_ratio) == 9, "R6 old ratio kept after strobe", int'(fb_ratio), 9);
        sync_pulse();
        check(1'b1, "R6 old cycle completed", 0, 0);
        next_cycle(l, r);
        check(l == 12, "R6 new ratio at boundary", l, 12);
        cfg_mint = 7'd50; cfg_mod_en = 1'b1; cfg_frac = 6'd5;
        for (int i = 0; i < 4; i++) begin
            next_cycle(l, r);
            check(l == 12, "R6 unstrobed inputs ignored", l, 12);
        end

        // R4 R5 R7: fractional mode, mid setting
        sync_pulse();
        do_load(10, 21, 1'b1);
        sync_pulse();
        next_cycle(l, r);
        check(l == 10, "R7 first cycle after apply", l, 10);
        run_period(sum, mn, mx, 10, "R4 length within MINT..MINT+1");
        check(sum == 10 * PERIOD + 43, "R5 period sum mid", sum, 10 * PERIOD + 43);

        // R9: largest MINT and largest fractional word
        sync_pulse();
        do_load(127, 63, 1'b1);
        sync_pulse();
        next_cycle(l, r);
        check(l == 127, "R7 first cycle after apply max", l, 127);
        run_period(sum, mn, mx, 127, "R4 length band max");
        check(sum == 127 * PERIOD + 127, "R5 period sum max", sum, 127 * PERIOD + 127);
        check(mx == 128, "R9 longest cycle", mx, 128);

        // R8: second strobe replaces the first
        sync_pulse();
        do_load(20, 0, 1'b0);
        do_load(14, 0, 1'b0);
        sync_pulse();
        for (int i = 0; i < 2; i++) begin
            next_cycle(l, r);
            check(l == 14, "R8 latest strobe wins", l, 14);
        end

        // R9: MINT of one with zero fractional word
        sync_pulse();
        do_load(1, 0, 1'b1);
        sync_pulse();
        next_cycle(l, r);
        check(l == 1, "R9 single-clock cycle", l, 1);
        run_period(sum, mn, mx, 1, "R4 length band min");
        check(sum == PERIOD + 1, "R5 period sum min", sum, PERIOD + 1);
        check(mn == 1, "R9 shortest cycle", mn, 1);

        finished = 1;
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            finished = 1;
            n_checks++;
            n_fail++;
            $display("FAIL watchdog actual=timeout expected=completion");
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    end

endmodule